// File: doc/BRIEF.md
# FEAC Code Word Receiver

This block watches the serial C3 overhead bit of a DS3 signal running in C-bit parity mode and recovers far-end alarm and control (FEAC) messages from it. Each message travels as a 16-bit word that repeats. The receiver finds the word boundary by searching for the flag at every bit position. It accepts a message only after seeing the same word several times in a row, and then acts on the 6-bit message it carries.

An accepted message falls into one of four classes: loopback activate, loopback deactivate, channel indication, or alarm (this class also covers unassigned codes). Alarm messages are latched into a code register and raise a sticky interrupt. Activate and deactivate are remembered as a pending command. The next accepted channel indication then sets or clears the loopback flag of the channel it names. Any other accepted message cancels the pending command.

The surrounding logic supplies one C3 bit per DS3 frame along with a valid strobe, and holds the mode input high while the line runs C-bit parity framing.

Top module: `feac_rx`

## Requirements
- R1: While `cbit_mode` is low, C3 bits are ignored and the framing, repeat count and pending command return to their idle state. Flags, code and interrupt keep their values.
- R2: A word is, in arrival order, eight 1s, a 0, message bits x0 then x1 through x5, and a final 0. The message value is x5..x0, with x5 as the most significant bit.
- R3: A message is accepted when the same well-formed word arrives 4 times in a row. Further identical repeats do not cause another acceptance.
- R4: The flag is searched for at every bit position. A malformed word, or a well-formed word with a different message, restarts the repeat count.
- R5: Message 000111 (activate) followed by an accepted channel indication sets the flag of that channel. Codes 100001..111100 map to flags 0..27, code 010011 maps to flag 28 and code 011011 maps to flag 29.
- R6: Message 011100 (deactivate) followed by an accepted channel indication clears the flag of that channel.
- R7: A channel indication with no pending command changes no flag. An activate or deactivate that is followed by an accepted message that is not a channel indication is discarded.
- R8: Any other accepted message is stored in `alarm_code` and sets `alarm_irq`. The interrupt stays high until `irq_clr` is pulsed. If a set and a clear arrive in the same cycle, the set wins.
- R9: After reset all flags, the code and the interrupt are zero.
- R10: Outputs change on the second clock edge after the edge that takes in the last bit of the accepting word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cbit_mode | input | 1 | High when the line runs C-bit parity framing |
| bit_vld | input | 1 | Qualifies `c3_bit` for one cycle |
| c3_bit | input | 1 | Received C3 bit |
| irq_clr | input | 1 | Clears the alarm interrupt |
| alarm_code | output | 6 | Last accepted alarm or unassigned message |
| alarm_irq | output | 1 | Sticky alarm interrupt |
| lb_flags | output | 30 | Per-channel loopback flags |

## Verification
The assertions check the following on every cycle: the framer and validator stay silent while the mode input is low, every acceptance is preceded by a well-formed word, the flags move only after an acceptance and never more than one at a time, the interrupt is sticky, and the code changes only together with the interrupt. Some properties can only be shown by the bench's scenarios: whether a given repeat count leads to acceptance, how the bit order maps to message values, the channel mapping table, the two-word command sequence and its cancellation, and the exact output latency. For these, a behavioural model compares the outputs on every clock.

// File: rtl/feac_pkg.sv
package feac_pkg;

    localparam int unsigned WORD_BITS     = 16;
    localparam int unsigned FLAG_BITS     = 8;
    localparam int unsigned MSG_BITS      = 6;
    localparam int unsigned CHAN_RUN_LO   = 33;
    localparam int unsigned CHAN_RUN_HI   = 60;
    localparam int unsigned NUM_CHAN      = CHAN_RUN_HI - CHAN_RUN_LO + 1 + 2;
    localparam int unsigned CHAN_IDX_BITS = $clog2(NUM_CHAN);

    typedef logic [MSG_BITS-1:0] msg_t;

    localparam msg_t MSG_ACT   = 6'b000111;
    localparam msg_t MSG_DEACT = 6'b011100;
    localparam msg_t MSG_CHX_A = 6'b010011;
    localparam msg_t MSG_CHX_B = 6'b011011;

    typedef enum logic [1:0] {
        CLS_ALARM,
        CLS_ACT,
        CLS_DEACT,
        CLS_CHAN
    } msg_cls_e;

    typedef enum logic [1:0] {
        PEND_NONE,
        PEND_SET,
        PEND_CLR
    } pend_e;

    typedef struct packed {
        logic good;
        msg_t msg;
    } word_t;

    // Window bit 0 is the oldest bit received.
    function automatic word_t parse_window(input logic [WORD_BITS-1:0] w);
        word_t r;
        r.good = (w[FLAG_BITS-1:0] == '1) && !w[FLAG_BITS] && !w[WORD_BITS-1];
        r.msg  = w[FLAG_BITS+1 +: MSG_BITS];
        return r;
    endfunction

    function automatic msg_cls_e classify(input msg_t m);
        msg_cls_e c;
        if (m == MSG_ACT)
            c = CLS_ACT;
        else if (m == MSG_DEACT)
            c = CLS_DEACT;
        else if (m == MSG_CHX_A || m == MSG_CHX_B ||
                 (m >= MSG_BITS'(CHAN_RUN_LO) && m <= MSG_BITS'(CHAN_RUN_HI)))
            c = CLS_CHAN;
        else
            c = CLS_ALARM;
        return c;
    endfunction

    function automatic logic [CHAN_IDX_BITS-1:0] chan_of(input msg_t m);
        logic [CHAN_IDX_BITS-1:0] idx;
        msg_t diff;
        diff = m - MSG_BITS'(CHAN_RUN_LO);
        if (m == MSG_CHX_A)
            idx = CHAN_IDX_BITS'(NUM_CHAN - 2);
        else if (m == MSG_CHX_B)
            idx = CHAN_IDX_BITS'(NUM_CHAN - 1);
        else
            idx = diff[CHAN_IDX_BITS-1:0];
        return idx;
    endfunction

endpackage

// File: rtl/feac_framer.sv
module feac_framer
    import feac_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  en,
    input  logic  bit_vld,
    input  logic  bit_in,
    output logic  word_stb,
    output word_t word_q
);

    localparam int unsigned POS_W = $clog2(WORD_BITS);
    localparam logic [POS_W-1:0] POS_LAST = POS_W'(WORD_BITS - 1);

    logic [WORD_BITS-1:0] win_q;
    logic [WORD_BITS-1:0] win_d;
    logic                 locked_q;
    logic [POS_W-1:0]     pos_q;
    word_t                cand;

    always_comb begin
        win_d = {bit_in, win_q[WORD_BITS-1:1]};
        cand  = parse_window(win_d);
    end

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            win_q    <= '0;
            locked_q <= 1'b0;
            pos_q    <= '0;
            word_stb <= 1'b0;
            word_q   <= '0;
        end else begin
            word_stb <= 1'b0;
            if (bit_vld) begin
                win_q <= win_d;
                if (!locked_q) begin
                    if (cand.good) begin
                        locked_q <= 1'b1;
                        pos_q    <= '0;
                        word_stb <= 1'b1;
                        word_q   <= cand;
                    end
                end else if (pos_q == POS_LAST) begin
                    pos_q    <= '0;
                    word_stb <= 1'b1;
                    word_q   <= cand;
                    locked_q <= cand.good;
                end else begin
                    pos_q <= pos_q + 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/feac_validator.sv
module feac_validator
    import feac_pkg::*;
#(
    parameter int unsigned REPEATS = 4
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  en,
    input  logic  word_stb,
    input  word_t word_in,
    output logic  acc_stb,
    output msg_t  acc_msg
);

    localparam int unsigned CNT_W = $clog2(REPEATS + 1);
    localparam logic [CNT_W-1:0] REP_MAX = CNT_W'(REPEATS);
    localparam logic [CNT_W-1:0] REP_PRE = CNT_W'(REPEATS - 1);
    localparam logic [CNT_W-1:0] REP_ONE = CNT_W'(1);

    logic [CNT_W-1:0] rep_q;
    msg_t             last_q;

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            rep_q   <= '0;
            last_q  <= '0;
            acc_stb <= 1'b0;
            acc_msg <= '0;
        end else begin
            acc_stb <= 1'b0;
            if (word_stb) begin
                acc_msg <= word_in.msg;
                if (!word_in.good) begin
                    rep_q <= '0;
                end else if (rep_q != '0 && word_in.msg == last_q) begin
                    if (rep_q != REP_MAX)
                        rep_q <= rep_q + 1'b1;
                    if (rep_q == REP_PRE)
                        acc_stb <= 1'b1;
                end else begin
                    rep_q  <= REP_ONE;
                    last_q <= word_in.msg;
                    if (REPEATS == 1)
                        acc_stb <= 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/feac_action.sv
module feac_action
    import feac_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                en,
    input  logic                acc_stb,
    input  msg_t                acc_msg,
    input  logic                irq_clr,
    output msg_t                alarm_code,
    output logic                alarm_irq,
    output logic [NUM_CHAN-1:0] lb_flags
);

    msg_cls_e                 cls;
    logic [CHAN_IDX_BITS-1:0] idx;
    logic                     take;
    logic                     chan_hit;
    logic                     alarm_hit;
    pend_e                    pend_q;

    always_comb begin
        cls       = classify(acc_msg);
        idx       = chan_of(acc_msg);
        take      = en && acc_stb;
        chan_hit  = take && (cls == CLS_CHAN);
        alarm_hit = take && (cls == CLS_ALARM);
    end

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            pend_q <= PEND_NONE;
        end else if (take) begin
            case (cls)
                CLS_ACT:   pend_q <= PEND_SET;
                CLS_DEACT: pend_q <= PEND_CLR;
                default:   pend_q <= PEND_NONE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            alarm_code <= '0;
            alarm_irq  <= 1'b0;
        end else begin
            if (alarm_hit)
                alarm_code <= acc_msg;
            if (alarm_hit)
                alarm_irq <= 1'b1;
            else if (irq_clr)
                alarm_irq <= 1'b0;
        end
    end

    for (genvar i = 0; i < NUM_CHAN; i++) begin : g_flag
        logic flag_q;
        always_ff @(posedge clk) begin
            if (rst) begin
                flag_q <= 1'b0;
            end else if (chan_hit && idx == CHAN_IDX_BITS'(i)) begin
                if (pend_q == PEND_SET)
                    flag_q <= 1'b1;
                else if (pend_q == PEND_CLR)
                    flag_q <= 1'b0;
            end
        end
        assign lb_flags[i] = flag_q;
    end

endmodule

// File: rtl/feac_rx.sv
module feac_rx
    import feac_pkg::*;
#(
    parameter int unsigned REPEATS = 4
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                cbit_mode,
    input  logic                bit_vld,
    input  logic                c3_bit,
    input  logic                irq_clr,
    output logic [MSG_BITS-1:0] alarm_code,
    output logic                alarm_irq,
    output logic [NUM_CHAN-1:0] lb_flags
);

    logic  word_stb;
    word_t word_q;
    logic  word_good;
    logic  acc_stb;
    msg_t  acc_msg;

    assign word_good = word_q.good;

    feac_framer u_framer (
        .clk      (clk),
        .rst      (rst),
        .en       (cbit_mode),
        .bit_vld  (bit_vld),
        .bit_in   (c3_bit),
        .word_stb (word_stb),
        .word_q   (word_q)
    );

    feac_validator #(.REPEATS(REPEATS)) u_validator (
        .clk      (clk),
        .rst      (rst),
        .en       (cbit_mode),
        .word_stb (word_stb),
        .word_in  (word_q),
        .acc_stb  (acc_stb),
        .acc_msg  (acc_msg)
    );

    feac_action u_action (
        .clk        (clk),
        .rst        (rst),
        .en         (cbit_mode),
        .acc_stb    (acc_stb),
        .acc_msg    (acc_msg),
        .irq_clr    (irq_clr),
        .alarm_code (alarm_code),
        .alarm_irq  (alarm_irq),
        .lb_flags   (lb_flags)
    );

endmodule

// File: rtl/feac_rx_chk.sv
module feac_rx_chk #(
    parameter int unsigned NCH = 30
) (
    input logic           clk,
    input logic           rst,
    input logic           cbit_mode,
    input logic           irq_clr,
    input logic           word_stb,
    input logic           word_good,
    input logic           acc_stb,
    input logic [5:0]     alarm_code,
    input logic           alarm_irq,
    input logic [NCH-1:0] lb_flags
);

    AST_MODE_OFF_QUIET: assert property (@(posedge clk) disable iff (rst)
        !cbit_mode |=> (!word_stb && !acc_stb)); // R1

    AST_ACC_AFTER_GOOD: assert property (@(posedge clk) disable iff (rst)
        acc_stb |-> $past(word_stb && word_good)); // R3

    AST_FLAGS_NEED_ACC: assert property (@(posedge clk) disable iff (rst)
        !acc_stb |=> $stable(lb_flags)); // R5

    AST_ONE_FLAG_STEP: assert property (@(posedge clk) disable iff (rst)
        $countones(lb_flags ^ $past(lb_flags)) <= 1); // R6

    AST_IRQ_STICKY: assert property (@(posedge clk) disable iff (rst)
        (alarm_irq && !irq_clr) |=> alarm_irq); // R8

    AST_CODE_WITH_IRQ: assert property (@(posedge clk) disable iff (rst)
        !$stable(alarm_code) |-> alarm_irq); // R8

endmodule

bind feac_rx feac_rx_chk #(.NCH(feac_pkg::NUM_CHAN)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .cbit_mode  (cbit_mode),
    .irq_clr    (irq_clr),
    .word_stb   (word_stb),
    .word_good  (word_good),
    .acc_stb    (acc_stb),
    .alarm_code (alarm_code),
    .alarm_irq  (alarm_irq),
    .lb_flags   (lb_flags)
);

// File: tb/feac_rx_bench.sv
`timescale 1ns/1ps
module feac_rx_bench;

    localparam int NCH = 30;

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic           cbit_mode = 1'b1;
    logic           bit_vld = 1'b0;
    logic           c3_bit = 1'b0;
    logic           irq_clr = 1'b0;
    logic [5:0]     alarm_code;
    logic           alarm_irq;
    logic [NCH-1:0] lb_flags;

    always #2 clk = ~clk;

    feac_rx u_feac_rx (
        .clk        (clk),
        .rst        (rst),
        .cbit_mode  (cbit_mode),
        .bit_vld    (bit_vld),
        .c3_bit     (c3_bit),
        .irq_clr    (irq_clr),
        .alarm_code (alarm_code),
        .alarm_irq  (alarm_irq),
        .lb_flags   (lb_flags)
    );

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    endtask

    // ---------------- behavioural reference model ----------------
    typedef struct { int due; int msg; } ev_t;
    ev_t  evq[$];
    int   hist[$];
    int   cyc = 0;
    bit   m_locked;
    int   m_since, m_rep, m_last, m_pend;
    logic [NCH-1:0] e_flags;
    logic [5:0]     e_code;
    logic           e_irq;

    function automatic bit is_chan(int m);
        return (m == 19) || (m == 27) || (m >= 33 && m <= 60);
    endfunction

    function automatic int chan_idx(int m);
        if (m == 19) return 28;
        if (m == 27) return 29;
        return m - 33;
    endfunction

    task automatic model_word(bit good, int msg);
        if (!good) begin
            m_rep = 0;
        end else if (m_rep > 0 && msg == m_last) begin
            if (m_rep == 3) evq.push_back('{due: cyc + 2, msg: msg});
            if (m_rep < 4) m_rep++;
        end else begin
            m_rep  = 1;
            m_last = msg;
        end
    endtask

    always @(posedge clk) begin
        bit set_now;
        cyc++;
        if (rst) begin
            evq.delete(); hist.delete();
            m_locked = 0; m_since = 0; m_rep = 0; m_last = 0; m_pend = 0;
            e_flags = '0; e_code = '0; e_irq = 1'b0;
        end else begin
            set_now = 0;
            while (evq.size() > 0 && evq[0].due <= cyc) begin
                int m;
                m = evq[0].msg;
                void'(evq.pop_front());
                if (m == 7) m_pend = 1;
                else if (m == 28) m_pend = 2;
                else if (is_chan(m)) begin
                    if (m_pend == 1) e_flags[chan_idx(m)] = 1'b1;
                    if (m_pend == 2) e_flags[chan_idx(m)] = 1'b0;
                    m_pend = 0;
                end else begin
                    e_code = 6'(m); set_now = 1; m_pend = 0;
                end
            end
            if (set_now) e_irq = 1'b1;
            else if (irq_clr) e_irq = 1'b0;
            if (!cbit_mode) begin
                hist.delete(); m_locked = 0; m_since = 0; m_rep = 0; m_pend = 0;
            end else if (bit_vld) begin
                bit good;
                int msg;
                hist.push_back(int'(c3_bit));
                if (hist.size() > 16) void'(hist.pop_front());
                good = (hist.size() == 16);
                msg = 0;
                if (good) begin
                    for (int i = 0; i < 8; i++) if (hist[i] != 1) good = 0;
                    if (hist[8] != 0 || hist[15] != 0) good = 0;
                    for (int i = 0; i < 6; i++) msg += hist[9 + i] << i;
                end
                if (!m_locked) begin
                    if (good) begin m_locked = 1; m_since = 0; model_word(1, msg); end
                end else begin
                    m_since++;
                    if (m_since == 16) begin
                        m_since = 0; model_word(good, msg); m_locked = good;
                    end
                end
            end
        end
    end

    // per-cycle comparison (R10: latency and all behaviour against the model)
    always @(negedge clk) begin
        if (!rst && !done) begin
            chk("R10 cycle flags", 32'(lb_flags), 32'(e_flags));
            chk("R10 cycle code", 32'(alarm_code), 32'(e_code));
            chk("R10 cycle irq", 32'(alarm_irq), 32'(e_irq));
        end
    end

    // ---------------- stimulus ----------------
    task automatic put_bit(input logic b);
        @(negedge clk); bit_vld = 1'b1; c3_bit = b;
        @(negedge clk); bit_vld = 1'b0;
    endtask

    task automatic put_word(input logic [5:0] m, input int n);
        for (int k = 0; k < n; k++) begin
            for (int i = 0; i < 8; i++) put_bit(1'b1);
            put_bit(1'b0);
            for (int i = 0; i < 6; i++) put_bit(m[i]);
            put_bit(1'b0);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse_clr();
        @(negedge clk); irq_clr = 1'b1;
        @(negedge clk); irq_clr = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL R10 watchdog actual=running expected=finished");
        done = 1;
        finish_run();
    end

    initial begin
        logic [31:0] fl;
        idle(3);
        rst = 1'b0;
        idle(2);
        // R9 reset state
        chk("R9 flags", 32'(lb_flags), 32'h0);
        chk("R9 code", 32'(alarm_code), 32'h0);
        chk("R9 irq", 32'(alarm_irq), 32'h0);

        // R2 / R4: arbitrary offset then asymmetric alarm message
        put_bit(1); put_bit(0); put_bit(1); put_bit(1); put_bit(0);
        put_word(6'b000010, 4);
        idle(4);
        chk("R2 code order", 32'(alarm_code), 32'h02);
        chk("R8 irq set", 32'(alarm_irq), 32'h1);

        pulse_clr(); idle(2);
        chk("R8 irq cleared", 32'(alarm_irq), 32'h0);

        // R3 / R4: three repeats, malformed word, three repeats -> nothing
        put_word(6'b001101, 3);
        for (int i = 0; i < 16; i++) put_bit(1'b0);
        put_word(6'b001101, 3);
        idle(4);
        chk("R4 malformed restarts", 32'(alarm_code), 32'h02);
        chk("R3 three not enough", 32'(alarm_irq), 32'h0);
        put_word(6'b001101, 1);
        idle(4);
        chk("R3 fourth accepts", 32'(alarm_code), 32'h0D);
        chk("R3 fourth irq", 32'(alarm_irq), 32'h1);

        // R3: continued repeats do not re-accept
        pulse_clr();
        put_word(6'b001101, 4);
        idle(4);
        chk("R3 no re-accept", 32'(alarm_irq), 32'h0);

        // R4: differing words interleaved
        put_word(6'b111110, 2); put_word(6'b000010, 2); put_word(6'b111110, 2);
        idle(4);
        chk("R4 different word restarts", 32'(alarm_irq), 32'h0);

        // R5 activate + channel codes
        put_word(6'b000111, 4); put_word(6'b100001, 4);
        put_word(6'b000111, 4); put_word(6'b010011, 4);
        put_word(6'b000111, 4); put_word(6'b011011, 4);
        put_word(6'b000111, 4); put_word(6'b111100, 4);
        idle(4);
        chk("R5 mapping", 32'(lb_flags), 32'h3800_0001);

        // R6 deactivate + channel
        put_word(6'b011100, 4); put_word(6'b100001, 4);
        idle(4);
        chk("R6 cleared", 32'(lb_flags), 32'h3800_0000);

        // R7 channel without command; command cancelled by alarm
        put_word(6'b100010, 4);
        idle(4);
        chk("R7 no pending", 32'(lb_flags), 32'h3800_0000);
        put_word(6'b000111, 4); put_word(6'b000010, 4); put_word(6'b100010, 4);
        idle(4);
        chk("R7 cancelled", 32'(lb_flags), 32'h3800_0000);
        chk("R7 alarm code", 32'(alarm_code), 32'h02);

        // R8 set wins over clear in the same cycle: clear held during acceptance
        @(negedge clk); irq_clr = 1'b1;
        @(negedge clk); irq_clr = 1'b0;
        @(negedge clk); irq_clr = 1'b1;
        put_word(6'b111111, 4);
        idle(4);
        irq_clr = 1'b0;
        idle(2);
        chk("R8 code latched", 32'(alarm_code), 32'h3F);
        pulse_clr(); idle(2);

        // R1 mode off
        cbit_mode = 1'b0; idle(3);
        fl = 32'(lb_flags);
        put_word(6'b000111, 4); put_word(6'b100010, 4); put_word(6'b000001, 4);
        idle(4);
        chk("R1 flags ignored", 32'(lb_flags), fl);
        chk("R1 code ignored", 32'(alarm_code), 32'h3F);
        chk("R1 irq ignored", 32'(alarm_irq), 32'h0);
        cbit_mode = 1'b1; idle(3);
        put_word(6'b000111, 4); put_word(6'b100010, 4);
        idle(4);
        chk("R1 resumes", 32'(lb_flags), 32'h3800_0002);

        done = 1;
        finish_run();
    end

endmodule